// File: doc/BRIEF.md
# Strided Local Memory Window

This block gives a byte-wide processor bus access to a large banked local memory through a few registers. Each access channel (a "window") holds a pointer inside one memory bank and a signed stride. When the bus writes the window's data register, the byte goes to memory at the pointer. When the bus reads it, the byte at the pointer comes back. After either transfer the pointer moves by the stride, so a run of plain data-register accesses walks through memory with no address arithmetic on the processor side.

Two windows share the single memory port. Memory traffic is decoupled from the bus. A write is queued and then issued. Each window keeps a one-byte prefetch of the location it points at, so a read answers in the same bus cycle. A global read-enable bit keeps reads from doing anything while it is clear. Processors that issue a dummy read before a write therefore cannot move a pointer by accident. The bank of each window comes from a dedicated input. The memory itself is an external synchronous RAM with one cycle of read latency.

Top module: `lmem_stride_port`

## Requirements
- R1: After a synchronous reset every pointer reads 0, every stride reads 1 and the read-enable bit reads 0.
- R2: The register map follows `bus_addr`. Window p uses addresses 4p+0 (pointer bits 7:0), 4p+1 (pointer bits above 7, only PTR_BITS-8 bits kept, the rest read 0), 4p+2 (stride) and 4p+3 (data). Address 4·NPORTS is the control register, whose bit 0 is read-enable. Every other address reads 0, and writes to it change nothing.
- R3: A write to a window's data register stores the byte in memory at {bank, pointer}.
- R4: With read-enable set, a read of a window's data register returns, in the same cycle, the memory byte at {bank, pointer}. This holds for bytes written through either window.
- R5: After each data transfer the pointer becomes (pointer + sign-extended 8-bit stride) mod 2^PTR_BITS.
- R6: With read-enable clear, a data register read returns 0 and leaves the pointer unchanged.
- R7: Each window has its own pointer and stride. Transfers on one window never change the other window's registers.
- R8: When several windows need the memory in the same cycle, the lowest-numbered window gets it and the others wait. After a data write on window 0, the queued write is issued in the next cycle. Window 0's refetch at its new pointer follows, and window 1's refetch comes in the cycle after that.
- R9: A window's memory accesses use the bank given on its slice of `bank_sel`, bits [p*BANK_BITS +: BANK_BITS]. A bank change takes effect for the following reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | NPORTS*BANK_BITS | Bank number for each window |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | clog2(4*NPORTS+1) | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | BANK_BITS+PTR_BITS | Memory byte address {bank, pointer} |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_en |

## Verification
The bench builds the block with PTR_BITS=10, BANK_BITS=1 and NPORTS=2. The whole memory is then 2048 bytes and is mirrored in the bench. Pointer wrap-around at 1024 is reached within a few dozen transfers. This lets the bench sweep strides of both signs, including the extremes -128 and +127, across the wrap boundary. It also exposes the top pointer byte's truncation to two bits and lets one window read back what the other wrote in either bank.

// File: rtl/lmem_stride_pkg.sv
package lmem_stride_pkg;

    typedef enum logic [1:0] {
        FLD_PTR_LO = 2'd0,
        FLD_PTR_HI = 2'd1,
        FLD_STRIDE = 2'd2,
        FLD_DATA   = 2'd3
    } win_field_e;

    typedef struct packed {
        logic set_lo;
        logic set_hi;
        logic set_stride;
        logic put_byte;
        logic get_byte;
    } win_cmd_t;

    localparam int CTRL_RDEN_BIT = 0;

    function automatic win_cmd_t decode_win_cmd(
        input logic       hit,
        input logic       wr,
        input win_field_e fld,
        input logic       rd_en
    );
        win_cmd_t c;
        c.set_lo     = hit && wr && (fld == FLD_PTR_LO);
        c.set_hi     = hit && wr && (fld == FLD_PTR_HI);
        c.set_stride = hit && wr && (fld == FLD_STRIDE);
        c.put_byte   = hit && wr && (fld == FLD_DATA);
        c.get_byte   = hit && !wr && (fld == FLD_DATA) && rd_en;
        return c;
    endfunction

endpackage

// File: rtl/lmem_win_arb.sv
module lmem_win_arb #(
    parameter int NPORTS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] req,
    output logic [NPORTS-1:0] grant
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (req[p] && !taken) begin
                grant[p] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    p_single_grant_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    p_low_first_r8: assert property (@(posedge clk) disable iff (rst)
        req[0] |-> grant[0]);
    p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);
endmodule

// File: rtl/lmem_win.sv
module lmem_win
    import lmem_stride_pkg::*;
#(
    parameter int PTR_BITS  = 16,
    parameter int BANK_BITS = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [BANK_BITS-1:0]          bank,
    input  win_cmd_t                      cmd,
    input  logic [7:0]                    wdata,
    input  logic                          mem_wr_ev,
    input  logic                          grant,
    input  logic [7:0]                    mem_rdata,
    output logic [PTR_BITS-1:0]           ptr,
    output logic [7:0]                    stride,
    output logic [7:0]                    pbuf,
    output logic                          req,
    output logic                          req_we,
    output logic [BANK_BITS+PTR_BITS-1:0] req_addr,
    output logic [7:0]                    req_wdata
);
    localparam int HI_BITS = PTR_BITS - 8;
    localparam int MAW     = BANK_BITS + PTR_BITS;

    logic [PTR_BITS-1:0]  ptr_q;
    logic [PTR_BITS-1:0]  stride_ext;
    logic [7:0]           stride_q;
    logic [BANK_BITS-1:0] bank_q;
    logic                 buf_valid;
    logic                 fetch_out;
    logic                 wq_valid;
    logic [MAW-1:0]       wq_addr;
    logic [7:0]           wq_data;
    logic [7:0]           buf_q;
    logic                 stale;

    assign stride_ext = {{HI_BITS{stride_q[7]}}, stride_q};
    assign stale = cmd.set_lo || cmd.set_hi || cmd.put_byte || cmd.get_byte
                   || (bank != bank_q) || mem_wr_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            stride_q  <= 8'd1;
            bank_q    <= '0;
            buf_valid <= 1'b0;
            fetch_out <= 1'b0;
            wq_valid  <= 1'b0;
            wq_addr   <= '0;
            wq_data   <= '0;
            buf_q     <= '0;
        end else begin
            bank_q <= bank;
            if (cmd.set_lo)
                ptr_q[7:0] <= wdata;
            if (cmd.set_hi)
                ptr_q[PTR_BITS-1:8] <= wdata[HI_BITS-1:0];
            if (cmd.put_byte || cmd.get_byte)
                ptr_q <= ptr_q + stride_ext;
            if (cmd.set_stride)
                stride_q <= wdata;

            if (cmd.put_byte) begin
                wq_valid <= 1'b1;
                wq_addr  <= {bank, ptr_q};
                wq_data  <= wdata;
            end else if (grant && wq_valid) begin
                wq_valid <= 1'b0;
            end

            fetch_out <= grant && !wq_valid && !stale;
            if (stale) begin
                buf_valid <= 1'b0;
            end else if (fetch_out) begin
                buf_valid <= 1'b1;
                buf_q     <= mem_rdata;
            end
        end
    end

    assign req       = wq_valid || (!buf_valid && !fetch_out);
    assign req_we    = wq_valid;
    assign req_addr  = wq_valid ? wq_addr : {bank, ptr_q};
    assign req_wdata = wq_data;
    assign ptr       = ptr_q;
    assign stride    = stride_q;
    assign pbuf      = buf_q;

    p_write_queued_r3: assert property (@(posedge clk) disable iff (rst)
        cmd.put_byte |=> (wq_valid && wq_data == $past(wdata)
                          && wq_addr == {$past(bank), $past(ptr_q)}));
    p_write_leaves_r3: assert property (@(posedge clk) disable iff (rst)
        (wq_valid && grant && !cmd.put_byte) |=> !wq_valid);
endmodule

// File: rtl/lmem_stride_port.sv
module lmem_stride_port
    import lmem_stride_pkg::*;
#(
    parameter int PTR_BITS  = 16,
    parameter int BANK_BITS = 3,
    parameter int NPORTS    = 2,
    localparam int BUS_AW   = $clog2(NPORTS * 4 + 1),
    localparam int MAW      = BANK_BITS + PTR_BITS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NPORTS*BANK_BITS-1:0] bank_sel,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [BUS_AW-1:0]           bus_addr,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    output logic                        mem_en,
    output logic                        mem_we,
    output logic [MAW-1:0]              mem_addr,
    output logic [7:0]                  mem_wdata,
    input  logic [7:0]                  mem_rdata
);
    localparam int PIDX_W  = BUS_AW - 2;
    localparam int HI_BITS = PTR_BITS - 8;
    localparam logic [BUS_AW-1:0] CTRL_ADDR = BUS_AW'(NPORTS * 4);

    logic                rd_en;
    logic                ctrl_hit;
    logic [PIDX_W-1:0]   win_idx;
    win_field_e          fld;
    logic                mem_wr_ev;

    win_cmd_t            cmd      [NPORTS];
    logic [PTR_BITS-1:0] ptr_w    [NPORTS];
    logic [7:0]          stride_w [NPORTS];
    logic [7:0]          pbuf_w   [NPORTS];
    logic [MAW-1:0]      raddr_w  [NPORTS];
    logic [7:0]          rwdat_w  [NPORTS];
    logic [NPORTS-1:0]   req;
    logic [NPORTS-1:0]   req_we;
    logic [NPORTS-1:0]   grant;

    assign win_idx  = bus_addr[BUS_AW-1:2];
    assign fld      = win_field_e'(bus_addr[1:0]);
    assign ctrl_hit = bus_sel && (bus_addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst)
            rd_en <= 1'b0;
        else if (ctrl_hit && bus_wr)
            rd_en <= bus_wdata[CTRL_RDEN_BIT];
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_win
        logic                hit;
        logic                rd_try;
        logic [PTR_BITS-1:0] stride_chk;

        assign hit    = bus_sel && (win_idx == PIDX_W'(p));
        assign rd_try = hit && !bus_wr && (fld == FLD_DATA);
        assign cmd[p] = decode_win_cmd(hit, bus_wr, fld, rd_en);
        assign stride_chk = {{HI_BITS{stride_w[p][7]}}, stride_w[p]};

        lmem_win #(
            .PTR_BITS (PTR_BITS),
            .BANK_BITS(BANK_BITS)
        ) u_win (
            .clk      (clk),
            .rst      (rst),
            .bank     (bank_sel[p*BANK_BITS +: BANK_BITS]),
            .cmd      (cmd[p]),
            .wdata    (bus_wdata),
            .mem_wr_ev(mem_wr_ev),
            .grant    (grant[p]),
            .mem_rdata(mem_rdata),
            .ptr      (ptr_w[p]),
            .stride   (stride_w[p]),
            .pbuf     (pbuf_w[p]),
            .req      (req[p]),
            .req_we   (req_we[p]),
            .req_addr (raddr_w[p]),
            .req_wdata(rwdat_w[p])
        );

        p_blocked_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (rd_try && !rd_en) |=> $stable(ptr_w[p]));
        p_blocked_zero_r6: assert property (@(posedge clk) disable iff (rst)
            (rd_try && !rd_en) |-> (bus_rdata == 8'd0));
        p_advance_r5: assert property (@(posedge clk) disable iff (rst)
            (rd_try && rd_en) |=> (ptr_w[p] == $past(ptr_w[p] + stride_chk)));
    end

    lmem_win_arb #(.NPORTS(NPORTS)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .grant(grant)
    );

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (grant[p]) begin
                mem_we    = req_we[p];
                mem_addr  = raddr_w[p];
                mem_wdata = rwdat_w[p];
            end
        end
    end
    assign mem_en    = |grant;
    assign mem_wr_ev = mem_en && mem_we;

    always_comb begin
        logic [7:0] hi_ext;
        bus_rdata = 8'd0;
        hi_ext    = 8'd0;
        if (bus_sel && !bus_wr) begin
            if (ctrl_hit)
                bus_rdata[CTRL_RDEN_BIT] = rd_en;
            for (int p = 0; p < NPORTS; p++) begin
                if (win_idx == PIDX_W'(p)) begin
                    unique case (fld)
                        FLD_PTR_LO: bus_rdata = ptr_w[p][7:0];
                        FLD_PTR_HI: begin
                            hi_ext[HI_BITS-1:0] = ptr_w[p][PTR_BITS-1:8];
                            bus_rdata = hi_ext;
                        end
                        FLD_STRIDE: bus_rdata = stride_w[p];
                        FLD_DATA:   bus_rdata = rd_en ? pbuf_w[p] : 8'd0;
                        default:    bus_rdata = 8'd0;
                    endcase
                end
            end
        end
    end

    p_idle_no_write_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> !mem_we);
endmodule

// File: tb/sim_lmem_stride_port.sv
module sim_lmem_stride_port;
    localparam int PB = 10;
    localparam int BB = 1;
    localparam int NP = 2;
    localparam int MSZ = 1 << (PB + BB);
    localparam int PMASK = (1 << PB) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP*BB-1:0] bank_sel = '0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic mem_en, mem_we;
    logic [PB+BB-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    logic [7:0] ram [MSZ];
    logic [7:0] mdl [MSZ];
    int bptr [NP];
    int bstep [NP];
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    lmem_stride_port #(.PTR_BITS(PB), .BANK_BITS(BB), .NPORTS(NP)) u0 (
        .clk(clk), .rst(rst), .bank_sel(bank_sel),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            mem_rdata <= ram[mem_addr];
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(a);
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_sel = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    function automatic int bank_of(input int p);
        return int'(bank_sel[p*BB +: BB]);
    endfunction

    function automatic int madr(input int p);
        return (bank_of(p) << PB) | bptr[p];
    endfunction

    function automatic int adv(input int p);
        return (bptr[p] + int'($signed(8'(bstep[p])))) & PMASK;
    endfunction

    task automatic set_ptr(input int p, input int v);
        wr(4*p + 0, v & 255);
        wr(4*p + 1, (v >> 8) & 255);
        bptr[p] = v & PMASK;
    endtask

    task automatic set_step(input int p, input int s);
        wr(4*p + 2, s & 255);
        bstep[p] = s & 255;
    endtask

    task automatic chk_ptr(input string rq, input int p);
        int lo, hi;
        rd(4*p + 0, lo);
        rd(4*p + 1, hi);
        chk(rq, (hi << 8) | lo, bptr[p]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int steps [8] = '{1, 255, 3, 128, 127, 251, 0, 17};
        for (int i = 0; i < MSZ; i++) begin
            ram[i] = 8'((i * 37 + 11) ^ (i >> 8));
            mdl[i] = ram[i];
        end
        for (int p = 0; p < NP; p++) begin bptr[p] = 0; bstep[p] = 1; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset values
        for (int p = 0; p < NP; p++) begin
            rd(4*p + 0, v); chk("R1 ptr lo", v, 0);
            rd(4*p + 1, v); chk("R1 ptr hi", v, 0);
            rd(4*p + 2, v); chk("R1 stride", v, 1);
        end
        rd(8, v); chk("R1 control", v, 0);

        // R6 reads blocked while read-enable clear
        rd(3, v); chk("R6 blocked data", v, 0);
        rd(3, v); chk("R6 blocked data again", v, 0);
        chk_ptr("R6 pointer unchanged", 0);

        // R2 register map and high byte truncation
        set_ptr(0, 16'h2A5);
        chk_ptr("R2 pointer readback", 0);
        wr(1, 8'hFF); bptr[0] = (bptr[0] & 255) | (3 << 8);
        rd(1, v); chk("R2 hi truncated", v, 3);
        rd(9, v); chk("R2 unmapped reads 0", v, 0);
        wr(12, 8'h55);
        wr(9, 8'h77);
        chk_ptr("R2 unmapped write ignored", 0);
        rd(2, v); chk("R2 stride untouched", v, 1);
        rd(8, v); chk("R2 control untouched", v, 0);
        chk_ptr("R7 window1 untouched", 1);

        // R3 and R5: write sweep with wrap on window 0, bank 0
        set_ptr(0, 10'h3F0);
        set_step(0, 3);
        for (int i = 0; i < 40; i++) begin
            int a;
            a = madr(0);
            wr(3, (i * 13 + 5) & 255);
            mdl[a] = 8'((i * 13 + 5) & 255);
            chk("R3 memory byte", int'(ram[a]), int'(mdl[a]));
            bptr[0] = adv(0);
        end
        chk_ptr("R5 pointer after write wrap", 0);
        chk_ptr("R7 window1 still untouched", 1);

        // R4 and R5: read sweep over strides on window 1, bank 1
        wr(8, 1);
        rd(8, v); chk("R2 control readback", v, 1);
        bank_sel[BB +: BB] = 1'b1;
        repeat (4) @(negedge clk);
        foreach (steps[k]) begin
            set_ptr(1, 10'h3F8 - k * 3);
            set_step(1, steps[k]);
            for (int i = 0; i < 12; i++) begin
                rd(7, v);
                chk("R4 read data", v, int'(mdl[madr(1)]));
                bptr[1] = adv(1);
            end
            chk_ptr("R5 pointer after read sweep", 1);
        end

        // R9 bank change on window 1 at the same pointer
        set_ptr(1, 10'h3F0);
        set_step(1, 0);
        rd(7, v); chk("R9 bank1 byte", v, int'(mdl[madr(1)]));
        bank_sel[BB +: BB] = 1'b0;
        repeat (4) @(negedge clk);
        rd(7, v); chk("R9 bank0 byte", v, int'(mdl[madr(1)]));

        // R4 and R7: window0 writes where window1 points, window1 sees it
        set_ptr(0, 10'h3F0);
        set_step(0, 5);
        wr(3, 8'hC3); mdl[10'h3F0] = 8'hC3; bptr[0] = adv(0);
        rd(7, v); chk("R4 cross-window coherence", v, 8'hC3);
        chk_ptr("R7 window1 pointer kept", 1);

        // R6 again after disabling reads
        wr(8, 0);
        rd(7, v); chk("R6 blocked after disable", v, 0);
        chk_ptr("R6 pointer kept", 1);
        wr(8, 1);

        // R8 arbitration order after a window0 write
        set_ptr(1, 10'h123);
        begin
            int old0;
            old0 = madr(0);
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 8'h5A;
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
            mdl[old0] = 8'h5A; bptr[0] = adv(0);
            chk("R8 write first", {mem_en, mem_we, int'(mem_addr)}, {1'b1, 1'b1, old0});
            @(negedge clk);
            chk("R8 window0 refetch", {mem_en, mem_we, int'(mem_addr)}, {1'b1, 1'b0, madr(0)});
            @(negedge clk);
            chk("R8 window1 refetch", {mem_en, mem_we, int'(mem_addr)}, {1'b1, 1'b0, madr(1)});
            repeat (6) @(negedge clk);
        end
        rd(3, v); chk("R4 read after write", v, int'(mdl[madr(0)]));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule